// File: doc/BRIEF.md
# Sequential 32-bit Integer Multiplier

This block multiplies two 32-bit integers over a fixed number of clock cycles. It returns one 32-bit half of the 64-bit product. A two-bit operation code picks the half and, for the upper half, the signedness of each operand. Three signedness choices are available: both operands two's complement, both unsigned, or the first operand signed and the second unsigned. The lower half does not depend on signedness, so one code covers it.

A request is taken when `req_valid_i` and `req_ready_o` are both high at a rising edge. The block then sign- or zero-extends both operands to 33 bits and runs one shift-and-add step per cycle over the 33 multiplier bits. In the last step, which covers the sign position, the partial product is subtracted rather than added. The chosen half is registered and `done_o` is raised for one cycle. `req_ready_o` is low from acceptance until the cycle after `done_o`, so requests offered in that window are not taken.

Top module: `mul_unit`

## Requirements
- R1: While reset is active and right after it is released, `req_ready_o` is 1, `done_o` is 0 and `res_o` is 0.
- R2: Operation code 00 returns product bits 31:0. The value is identical whether the operands are read as signed or unsigned.
- R3: Operation code 01 reads both operands as two's complement and returns product bits 63:32.
- R4: Operation code 11 reads both operands as unsigned and returns product bits 63:32.
- R5: Operation code 10 reads `req_a_i` as two's complement and `req_b_i` as unsigned, and returns product bits 63:32.
- R6: `done_o` rises on the 33rd rising edge after the accepting edge and stays high for exactly one cycle.
- R7: `req_ready_o` is low from the accepting edge until `done_o` has dropped. Requests presented in that window are ignored, and the result reflects only the accepted operands and code.
- R8: With code 01, 0x80000000 times 0x80000000 yields 0x40000000.
- R9: `res_o` keeps its value in every cycle where `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle and able to accept |
| req_op_i | input | 2 | Operation code (00 low, 01 signed high, 10 signed-by-unsigned high, 11 unsigned high) |
| req_a_i | input | 32 | First operand |
| req_b_i | input | 32 | Second operand |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| res_o | output | 32 | Selected product half |

## Verification
The assertions take two things for granted. Reset is applied before the first request. Inputs change only away from the rising edge, so a request is judged on one stable sample. The stimulus drives every input on the falling edge. It offers a new request only while `req_ready_o` is high, except for deliberate requests made while the block is busy, and those are withdrawn before ready returns. Operands come from a seeded generator mixed with the extreme values 0, 1, all-ones and the most negative number, and every code is used.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic [1:0] {
        OP_LO  = 2'b00,
        OP_HSS = 2'b01,
        OP_HSU = 2'b10,
        OP_HUU = 2'b11
    } mul_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10
    } mul_st_e;
endpackage

// File: rtl/mul_opnd_ext.sv
module mul_opnd_ext #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic         sgn_i,
    output logic [W:0]   ext_o
);
    always_comb begin
        ext_o = {sgn_i & val_i[W-1], val_i};
    end
endmodule

// File: rtl/mul_step.sv
module mul_step #(
    parameter int PW = 66
) (
    input  logic [PW-1:0] acc_i,
    input  logic [PW-1:0] mcand_i,
    input  logic          take_i,
    input  logic          neg_i,
    output logic [PW-1:0] acc_o
);
    always_comb begin
        if (!take_i) begin
            acc_o = acc_i;
        end else if (neg_i) begin
            acc_o = acc_i - mcand_i;
        end else begin
            acc_o = acc_i + mcand_i;
        end
    end
endmodule

// File: rtl/mul_half_sel.sv
module mul_half_sel #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] prod_i,
    input  logic           hi_i,
    output logic [W-1:0]   res_o
);
    always_comb begin
        res_o = hi_i ? prod_i[2*W-1:W] : prod_i[W-1:0];
    end
endmodule

// File: rtl/mul_unit.sv
module mul_unit
    import mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid_i,
    output logic         req_ready_o,
    input  logic [1:0]   req_op_i,
    input  logic [W-1:0] req_a_i,
    input  logic [W-1:0] req_b_i,
    output logic         done_o,
    output logic [W-1:0] res_o
);
    localparam int XW = W + 1;
    localparam int PW = 2 * XW;
    localparam int CW = $clog2(XW + 1);

    typedef struct packed {
        mul_st_e         st;
        logic [CW-1:0]   cnt;
        logic [PW-1:0]   acc;
        logic [PW-1:0]   mcand;
        logic [XW-1:0]   mplier;
        mul_op_e         op;
        logic [W-1:0]    res;
    } regs_t;

    regs_t r_q, r_d;

    logic          a_sgn, b_sgn, last;
    logic [XW-1:0] a_ext, b_ext;
    logic [PW-1:0] acc_nx;
    logic [W-1:0]  res_nx;

    assign a_sgn = (req_op_i == OP_HSS) || (req_op_i == OP_HSU);
    assign b_sgn = (req_op_i == OP_HSS);
    assign last  = (r_q.cnt == CW'(W));

    mul_opnd_ext #(.W(W)) u_ext_a (.val_i(req_a_i), .sgn_i(a_sgn), .ext_o(a_ext));
    mul_opnd_ext #(.W(W)) u_ext_b (.val_i(req_b_i), .sgn_i(b_sgn), .ext_o(b_ext));

    mul_step #(.PW(PW)) u_step (
        .acc_i   (r_q.acc),
        .mcand_i (r_q.mcand),
        .take_i  (r_q.mplier[0]),
        .neg_i   (last),
        .acc_o   (acc_nx)
    );

    mul_half_sel #(.W(W)) u_sel (
        .prod_i (acc_nx[2*W-1:0]),
        .hi_i   (r_q.op != OP_LO),
        .res_o  (res_nx)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    r_d.st     = ST_RUN;
                    r_d.cnt    = '0;
                    r_d.acc    = '0;
                    r_d.mcand  = {{XW{a_ext[XW-1]}}, a_ext};
                    r_d.mplier = b_ext;
                    r_d.op     = mul_op_e'(req_op_i);
                end
            end
            ST_RUN: begin
                r_d.acc    = acc_nx;
                r_d.mcand  = r_q.mcand << 1;
                r_d.mplier = r_q.mplier >> 1;
                r_d.cnt    = r_q.cnt + CW'(1);
                if (last) begin
                    r_d.st  = ST_DONE;
                    r_d.res = res_nx;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready_o = (r_q.st == ST_IDLE);
    assign done_o      = (r_q.st == ST_DONE);
    assign res_o       = r_q.res;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(r_q.cnt) == CW'(W))); // R6
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o); // R7
    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |=> $stable(r_q.op)); // R7
    AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(res_o)); // R9
endmodule

// File: tb/sim_mul_unit.sv
`timescale 1ns/1ps
module sim_mul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_a = '0;
    logic [31:0] req_b = '0;
    logic        done;
    logic [31:0] res;

    int n_chk = 0;
    int n_err = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    mul_unit #(.W(32)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_op_i    (req_op),
        .req_a_i     (req_a),
        .req_b_i     (req_b),
        .done_o      (done),
        .res_o       (res)
    );

    function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] xa, xb, p;
        xa = (op == 2'b01 || op == 2'b10) ? {{32{a[31]}}, a} : {32'b0, a};
        xb = (op == 2'b01) ? {{32{b[31]}}, b} : {32'b0, b};
        p  = xa * xb;
        return (op == 2'b00) ? p[31:0] : p[63:32];
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic run_op(input string tag, input logic [1:0] op, input logic [31:0] a,
                          input logic [31:0] b, input bit noisy);
        int n;
        logic [31:0] exp, got;
        exp = model(op, a, b);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
        @(negedge clk);
        n = 1;
        chk("R7 ready low after accept", {31'b0, req_ready}, 32'd0);
        if (noisy) begin
            req_a = ~a; req_b = b + 32'd7; req_op = ~op; req_valid = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        // done visible after the 33rd edge past acceptance -> 34th falling edge
        chk("R6 latency", n, 34);
        chk(tag, res, exp);
        got = res;
        @(negedge clk);
        chk("R6 done single cycle", {31'b0, done}, 32'd0);
        chk("R9 result held", res, got);
        chk("R7 ready back", {31'b0, req_ready}, 32'd1);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] corners [4];
        int seed_dummy;
        corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
        corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h8000_0000;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {31'b0, req_ready}, 32'd1);
        chk("R1 done in reset", {31'b0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R1 done after reset", {31'b0, done}, 32'd0);
        chk("R1 result after reset", res, 32'd0);

        run_op("R8 min squared signed", 2'b01, 32'h8000_0000, 32'h8000_0000, 0);
        chk("R8 constant", model(2'b01, 32'h8000_0000, 32'h8000_0000), 32'h4000_0000);
        run_op("R3 minus one squared", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op("R4 all ones squared", 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op("R5 minus one by max", 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op("R2 low all ones", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op("R7 ignored busy request", 2'b01, 32'h1234_5678, 32'h9ABC_DEF0, 1);

        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                for (int k = 0; k < 4; k++) begin
                    run_op(op_tag(2'(k)), 2'(k), corners[i], corners[j], 0);
                end
            end
        end

        for (int t = 0; t < 200; t++) begin
            logic [1:0] op;
            logic [31:0] a, b;
            op = 2'($urandom);
            a = $urandom;
            b = $urandom;
            if ($urandom % 8 == 0) a = corners[$urandom % 4];
            if ($urandom % 8 == 0) b = corners[$urandom % 4];
            run_op(op_tag(op), op, a, b, ($urandom % 4) == 0);
        end
        summary();
    end
endmodule